// File: doc/BRIEF.md
# Supply-Guarded Byte Static Memory

This block is a clocked model of a 2048-by-8 static memory driven through active-low select, read-enable and write-enable controls. Instead of a tristate pad, the read path has a data-out bus, a drive flag and a data-valid flag. The valid flag rises only after a programmable access latency has elapsed following the last change of address or control.

An 8-bit digitized supply code is compared with two threshold inputs on every clock. The first is the fail level and the second is the lower switchover level. The result is a 2-bit operating mode. Outside normal mode, every control is ignored, the data bus is never driven and writes are blocked. This blocking takes effect in the very cycle the supply code leaves tolerance. The stored bytes are kept through every mode. Normal mode returns only after the supply code has been within tolerance for a qualification run of consecutive clock edges.

Top module: `pfsram_top`

## Requirements
- R1: `mode` is 2'b00 (normal) only when `vcode > thr_fail`. With the supply out of tolerance, `mode` is 2'b10 (backup) when `vcode <= thr_swo` and 2'b01 (protected) otherwise. The mode changes combinationally in the same cycle that `vcode` changes.
- R2: After reset, or after any cycle with `vcode <= thr_fail`, `mode` reaches normal only after RECOVER_CYC consecutive rising edges with `vcode > thr_fail`. A single out-of-tolerance cycle restarts the count.
- R3: In normal mode, with `ce_n`=0 and `we_n`=0, `din` is stored at `addr` on the clock edge, whatever the level of `oe_n`.
- R4: `dout_en` is 1 only in normal mode with `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R5: With `ce_n`=1, nothing is written and `dout_en` stays 0.
- R6: With `ce_n`=0 and both `oe_n`=1 and `we_n`=1, the bus is not driven (`dout_en`=0, `dout_vld`=0) and nothing is written.
- R7: While reading, `dout_vld` is 0 in the cycle that `addr`, `ce_n` or `oe_n` changes. It stays 0 for the next RD_LAT rising edges and rises after edge RD_LAT+1 if the inputs are held.
- R8: When `dout_vld` is 1, `dout` equals the byte stored at `addr`. When `dout_vld` is 0, `dout` is 0.
- R9: A write request presented in a cycle where the supply is out of tolerance leaves the array unchanged.
- R10: Stored bytes survive passes through protected and backup modes.
- R11: In backup mode (and in protected mode), all controls are ignored: `dout_en`=0, `dout_vld`=0 and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero unless valid |
| dout_en | output | 1 | Bus drive flag |
| dout_vld | output | 1 | Read data valid after access latency |
| vcode | input | 8 | Digitized supply level |
| thr_fail | input | 8 | Power-fail threshold |
| thr_swo | input | 8 | Battery switchover threshold |
| mode | output | 2 | 00 normal, 01 protected, 10 backup |

## Verification
The delicate coincidence is a write request and a supply-fault detection falling in the same cycle. The bench asserts select and write-enable with new data and drops the supply code at the same falling edge, so the rising edge that would store the byte sees the fault. It judges the outcome by letting the supply qualify again and reading the address back through the normal read path, where the old byte must appear. The same is done with the code driven straight into the backup range.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;
   typedef enum logic [1:0] {
      PF_NORMAL = 2'b00,
      PF_PROT   = 2'b01,
      PF_BACKUP = 2'b10
   } pf_mode_e;
endpackage

// File: rtl/pfsram_supply_mon.sv
module pfsram_supply_mon
   import pfsram_pkg::*;
#(
   parameter int VCODE_W     = 8,
   parameter int RECOVER_CYC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VCODE_W-1:0] vcode,
   input  logic [VCODE_W-1:0] thr_fail,
   input  logic [VCODE_W-1:0] thr_swo,
   output pf_mode_e           mode
);
   localparam int CW = (RECOVER_CYC < 2) ? 1 : $clog2(RECOVER_CYC);

   logic          in_tol;
   logic          at_swo;
   logic          run_q;
   logic [CW-1:0] cnt_q;

   assign in_tol = vcode > thr_fail;
   assign at_swo = vcode <= thr_swo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (!in_tol) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (!run_q) begin
         if (cnt_q == CW'(RECOVER_CYC - 1)) begin
            run_q <= 1'b1;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (run_q && in_tol)  mode = PF_NORMAL;
      else if (at_swo)      mode = PF_BACKUP;
      else                  mode = PF_PROT;
   end
endmodule

// File: rtl/pfsram_lat_track.sv
module pfsram_lat_track #(
   parameter int ADDR_W = 11,
   parameter int RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   output logic              vld
);
   localparam int LW = $clog2(RD_LAT + 1);

   logic [ADDR_W-1:0] addr_q;
   logic              ce_q;
   logic              oe_q;
   logic [LW-1:0]     lat_q;
   logic              chg;

   assign chg = (addr != addr_q) || (ce_n != ce_q) || (oe_n != oe_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         ce_q   <= 1'b1;
         oe_q   <= 1'b1;
         lat_q  <= '0;
      end else begin
         addr_q <= addr;
         ce_q   <= ce_n;
         oe_q   <= oe_n;
         if (!rd_act || chg)                lat_q <= '0;
         else if (lat_q != LW'(RD_LAT))     lat_q <= lat_q + 1'b1;
      end
   end

   assign vld = rd_act && !chg && (lat_q == LW'(RD_LAT));
endmodule

// File: rtl/pfsram_array.sv
module pfsram_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rd_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[addr] <= din;
      rd_q <= cells[addr];
   end
endmodule

// File: rtl/pfsram_top.sv
module pfsram_top
   import pfsram_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int VCODE_W     = 8,
   parameter int RD_LAT      = 2,
   parameter int RECOVER_CYC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce_n,
   input  logic               oe_n,
   input  logic               we_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  din,
   output logic [DATA_W-1:0]  dout,
   output logic               dout_en,
   output logic               dout_vld,
   input  logic [VCODE_W-1:0] vcode,
   input  logic [VCODE_W-1:0] thr_fail,
   input  logic [VCODE_W-1:0] thr_swo,
   output logic [1:0]         mode
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("pfsram_top: ADDR_W out of range");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("pfsram_top: RD_LAT must be at least 1");
      end
      if (RECOVER_CYC < 1) begin : g_bad_rec
         $error("pfsram_top: RECOVER_CYC must be at least 1");
      end
   endgenerate

   pf_mode_e          mode_w;
   logic              run_ok;
   logic              wr_en;
   logic              vld;
   logic [DATA_W-1:0] rd_q;

   pfsram_supply_mon #(.VCODE_W(VCODE_W), .RECOVER_CYC(RECOVER_CYC)) mon_i (
      .clk(clk), .rst_n(rst_n), .vcode(vcode),
      .thr_fail(thr_fail), .thr_swo(thr_swo), .mode(mode_w)
   );

   assign run_ok  = (mode_w == PF_NORMAL);
   assign wr_en   = run_ok && !ce_n && !we_n;
   assign dout_en = run_ok && !ce_n && !oe_n && we_n;

   pfsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
      .clk(clk), .wr_en(wr_en), .addr(addr), .din(din), .rd_q(rd_q)
   );

   pfsram_lat_track #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) lat_i (
      .clk(clk), .rst_n(rst_n), .rd_act(dout_en), .addr(addr),
      .ce_n(ce_n), .oe_n(oe_n), .vld(vld)
   );

   assign dout_vld = vld;
   assign dout     = vld ? rd_q : '0;
   assign mode     = mode_w;
endmodule

// File: rtl/pfsram_chk.sv
module pfsram_chk #(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter int VCODE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ce_n,
   input logic               oe_n,
   input logic               we_n,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  dout,
   input logic               dout_en,
   input logic               dout_vld,
   input logic [VCODE_W-1:0] vcode,
   input logic [VCODE_W-1:0] thr_fail,
   input logic [VCODE_W-1:0] thr_swo,
   input logic [1:0]         mode
);
   assert_fault_not_normal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (vcode <= thr_fail) |-> (mode != 2'b00));

   assert_backup_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_swo < thr_fail && vcode <= thr_swo) |-> (mode == 2'b10));

   assert_recover_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && $past(mode) != 2'b00) |-> $past(vcode > thr_fail));

   assert_vld_needs_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> dout_en);

   assert_addr_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != $past(addr)) |-> !dout_vld);

   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_vld && $past(dout_vld)) |-> $stable(dout));

   assert_backup_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> (!dout_en && !dout_vld));
endmodule

bind pfsram_top pfsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VCODE_W(VCODE_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .addr(addr), .dout(dout), .dout_en(dout_en), .dout_vld(dout_vld),
   .vcode(vcode), .thr_fail(thr_fail), .thr_swo(thr_swo), .mode(mode)
);

// File: tb/pfsram_top_tb_top.sv
`timescale 1ns/1ps
module pfsram_top_tb_top;
   localparam int RD_LAT = 2;
   localparam int REC    = 4;
   localparam logic [7:0] V_GOOD = 8'hE0;
   localparam logic [7:0] V_PROT = 8'hA0;
   localparam logic [7:0] V_BACK = 8'h60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [10:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_en, dout_vld;
   logic [7:0]  vcode = V_GOOD;
   logic [7:0]  thr_fail = 8'hC0;
   logic [7:0]  thr_swo = 8'h80;
   logic [1:0]  mode;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   pfsram_top #(.RD_LAT(RD_LAT), .RECOVER_CYC(REC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .dout_vld(dout_vld), .vcode(vcode), .thr_fail(thr_fail),
      .thr_swo(thr_swo), .mode(mode)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic do_write(input logic [10:0] a, input logic [7:0] d, input logic oe);
      addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
      step();
      idle();
   endtask

   task automatic read_expect(input logic [10:0] a, input logic [7:0] d, input string req);
      addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk(dout_vld == 1'b0, "R7", "vld in change cycle", dout_vld, 0);
      chk(dout == 8'h00, "R8", "dout while invalid", dout, 0);
      for (int k = 1; k <= RD_LAT; k++) begin
         step();
         chk(dout_vld == 1'b0, "R7", "vld before latency", dout_vld, 0);
      end
      step();
      chk(dout_en == 1'b1, "R4", "drive during read", dout_en, 1);
      chk(dout_vld == 1'b1, "R7", "vld after latency", dout_vld, 1);
      chk(dout == d, req, "read data", dout, d);
      idle();
      step();
   endtask

   task automatic requalify();
      vcode = V_GOOD;
      for (int k = 1; k <= REC; k++) step();
      chk(mode == 2'b00, "R2", "mode after requalify", mode, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; idle(); vcode = V_GOOD;
      step(); step();
      chk(mode == 2'b01, "R2", "mode in reset", mode, 1);
      chk(dout_en == 1'b0 && dout_vld == 1'b0, "R4", "no drive in reset", dout_en, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_powerup();
      for (int k = 1; k < REC; k++) begin
         step();
         chk(mode == 2'b01, "R2", "mode during qualification", mode, 1);
      end
      step();
      chk(mode == 2'b00, "R2", "mode after qualification", mode, 0);
   endtask

   task automatic t_rw();
      do_write(11'h000, 8'h5A, 1'b1);
      do_write(11'h7FF, 8'hC3, 1'b0);   // R3: oe_n low during write
      do_write(11'h123, 8'h81, 1'b1);
      read_expect(11'h000, 8'h5A, "R3");
      read_expect(11'h7FF, 8'hC3, "R3");
      read_expect(11'h123, 8'h81, "R8");
   endtask

   task automatic t_quiet_controls();
      addr = 11'h123; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      for (int k = 0; k < RD_LAT + 2; k++) begin
         step();
         chk(dout_en == 1'b0 && dout_vld == 1'b0, "R6", "no drive oe high", dout_en, 0);
         chk(dout == 8'h00, "R6", "dout zero oe high", dout, 0);
      end
      idle();
      addr = 11'h123; din = 8'hFF; we_n = 1'b0; oe_n = 1'b0;
      step();
      chk(dout_en == 1'b0, "R5", "no drive ce high", dout_en, 0);
      idle();
      read_expect(11'h123, 8'h81, "R5");
   endtask

   task automatic t_addr_change();
      addr = 11'h000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      for (int k = 0; k <= RD_LAT; k++) step();
      chk(dout_vld == 1'b1 && dout == 8'h5A, "R8", "valid before change", dout, 8'h5A);
      addr = 11'h7FF;
      #1;
      chk(dout_vld == 1'b0, "R7", "vld drop on addr change", dout_vld, 0);
      for (int k = 0; k <= RD_LAT; k++) step();
      chk(dout_vld == 1'b1 && dout == 8'hC3, "R7", "valid new addr", dout, 8'hC3);
      oe_n = 1'b1;
      step();
      oe_n = 1'b0;
      #1;
      chk(dout_vld == 1'b0, "R7", "vld drop on oe toggle", dout_vld, 0);
      idle();
      step();
   endtask

   task automatic t_fault_abort();
      addr = 11'h123; din = 8'h3C; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      vcode = V_PROT;
      #1;
      chk(mode == 2'b01, "R1", "protected same cycle", mode, 1);
      step();
      addr = 11'h123; we_n = 1'b1; oe_n = 1'b0;
      step();
      chk(dout_en == 1'b0, "R11", "no drive when protected", dout_en, 0);
      idle();
      requalify();
      read_expect(11'h123, 8'h81, "R9");
   endtask

   task automatic t_backup();
      addr = 11'h7FF; din = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
      vcode = V_BACK;
      #1;
      chk(mode == 2'b10, "R1", "backup mode", mode, 2);
      step(); step();
      we_n = 1'b1;
      step();
      chk(dout_en == 1'b0 && dout_vld == 1'b0, "R11", "ignored in backup", dout_en, 0);
      idle();
      vcode = V_PROT;
      step();
      chk(mode == 2'b01, "R1", "protected above switchover", mode, 1);
      requalify();
      read_expect(11'h7FF, 8'hC3, "R10");
      read_expect(11'h000, 8'h5A, "R10");
   endtask

   task automatic t_glitch();
      vcode = V_PROT;
      step();
      vcode = V_GOOD;
      for (int k = 1; k < REC; k++) step();
      vcode = V_PROT;
      step();
      vcode = V_GOOD;
      for (int k = 1; k < REC; k++) step();
      chk(mode == 2'b01, "R2", "count restarted by glitch", mode, 1);
      step();
      chk(mode == 2'b00, "R2", "normal after full run", mode, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_powerup();
      t_rw();
      t_quiet_controls();
      t_addr_change();
      t_fault_abort();
      t_backup();
      t_glitch();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule